// File: doc/BRIEF.md
# SD Host Single-Segment DMA Engine

This block moves one contiguous buffer between system memory and the data path of an SD/SDIO host controller. Software programs a mode word, a buffer address and the transfer length, then writes a start command. Channel 0 carries card writes: it reads words from memory over a request/acknowledge bus and presents them on an outgoing valid/ready stream. Channel 1 carries card reads: it accepts words from an incoming valid/ready stream and writes them to memory.

The transfer length in bytes is the block count times the block size, both taken from input ports when the start is accepted. One data word (4 bytes) moves per beat. When the last beat finishes, the engine sets a completion flag for the channel. A start with a buffer address that is not a multiple of 128 does not run. It sets an error flag for the channel instead. Each channel can be held in reset through an active-low bit, and holding it aborts any transfer in flight. A single interrupt line combines every flag that its mask leaves open.

Registers sit on a 64-bit-spaced map, and only their low 32 bits carry state. The offsets are: mode 0x820, control 0x828, channel reset 0x830, completion flags 0x840, completion mask 0x848, error flags 0x850, error mask 0x858, buffer address 0x880.

Top module: `sd_dma_engine`

## Requirements
- R1: The mode register (0x820) and the address register (0x880) read back the value last written to them. Bits 63:32 of every register read back as 0.
- R2: After reset, both mask registers read 0xFFFFFFFF, both flag registers read 0, the channel reset register reads 0xFFFFFFFF, and irq is 0.
- R3: When mode bit 16 is 0 (channel 0), each beat reads one memory word with mem_we low and sends that word unchanged, in order, on tx_data. mem_req and tx_valid each stay asserted, with stable address and data, until they are accepted.
- R4: When mode bit 16 is 1 (channel 1), each word taken from rx_data is written to memory with mem_we high. Words are written in the order they arrive.
- R5: When mode bit 0 is 1, the memory address starts at the programmed buffer address and rises by 4 after each beat. When mode bit 0 is 0, every beat uses the programmed buffer address.
- R6: A transfer moves blk_cnt × blk_size / 4 words. When the last word has moved, completion flag bit 16 (channel 0) or bit 17 (channel 1) is set. A zero length sets the flag with no bus activity.
- R7: A start with a buffer address whose low 7 bits are not all zero causes no bus or stream activity. It sets error flag bit 16 or 17 of the selected channel.
- R8: A start command that arrives while a transfer is running is ignored. The running transfer keeps its address and length.
- R9: Bit 8 (channel 0) and bit 9 (channel 1) of the reset register at 0x830 are active-low holds. Writing 0 aborts that channel's transfer without setting its completion flag, and blocks starts on that channel until a 1 is written. All other bits of that register read back as 1.
- R10: A write to a flag register clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. Writing 0 clears all of the flags.
- R11: irq is high exactly when some completion or error flag is set and its bit in the matching mask register is 0.
- R12: A write to the control register (0x828) starts a transfer only when bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational from reg_addr) |
| blk_cnt | input | 32 | Number of blocks in the transfer |
| blk_size | input | 12 | Bytes per block |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| tx_valid | output | 1 | Outgoing card word valid |
| tx_data | output | 32 | Outgoing card word |
| tx_ready | input | 1 | Card side takes the outgoing word |
| rx_valid | input | 1 | Incoming card word valid |
| rx_data | input | 32 | Incoming card word |
| rx_ready | output | 1 | Engine takes the incoming word |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The hardest case to reach from the ports is an abort in the middle of a channel 1 transfer. The reset bit must drop after some memory writes have finished and before the last one. The stimulus polls the bench's count of memory writes and drops the hold bit once two have completed. It then checks that the write count stops growing, that the completion flag stays clear, and that a start on the held channel does nothing. A second hard case is a start that arrives mid-transfer. The bench sends it right after the first start, while the random acknowledge and ready delays keep the transfer busy.

// File: rtl/sd_dma_pkg.sv
// Shared register offsets, field positions and mover states for the SD DMA engine.
package sd_dma_pkg;
    localparam logic [11:0] OFS_MODE      = 12'h820;
    localparam logic [11:0] OFS_CTRL      = 12'h828;
    localparam logic [11:0] OFS_CHRST     = 12'h830;
    localparam logic [11:0] OFS_DONE      = 12'h840;
    localparam logic [11:0] OFS_DONE_MSK  = 12'h848;
    localparam logic [11:0] OFS_FAULT     = 12'h850;
    localparam logic [11:0] OFS_FAULT_MSK = 12'h858;
    localparam logic [11:0] OFS_BUFADDR   = 12'h880;

    localparam int MODE_CHAN_BIT = 16;   // 0: memory to card, 1: card to memory
    localparam int MODE_INC_BIT  = 0;    // 1: incrementing address
    localparam int CHRST_LO      = 8;    // bits 9:8 active-low channel holds
    localparam int FLAG_LO       = 16;   // bits 17:16 per-channel flags

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_MEM  = 2'd1,
        MV_CARD = 2'd2
    } mv_state_e;
endpackage

// File: rtl/sd_dma_regs.sv
// Register file of the SD DMA engine.
// Decodes writes, holds mode, address, channel holds, flags and masks, qualifies
// start commands (busy, held channel, alignment) and forms the interrupt.
// Assumes one register write per cycle; reads are combinational.
module sd_dma_regs
    import sd_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              done_chan_i,
    output logic              start_o,
    output logic              chan_o,
    output logic              inc_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [1:0]        hold_o,
    output logic [31:0]       done_mask_o,
    output logic [31:0]       fault_mask_o,
    output logic              irq_o
);
    logic [31:0]       mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        chrst_q;
    logic [1:0]        done_q;
    logic [1:0]        fault_q;
    logic [31:0]       dmsk_q;
    logic [31:0]       fmsk_q;
    logic              start_req;
    logic              misaligned;
    logic [31:0]       chrst_view;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[63:32];

    // Qualify a start: control bit 0 set, engine idle, selected channel released.
    always_comb begin
        start_req  = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0]
                     && !busy_i && chrst_q[mode_q[MODE_CHAN_BIT]];
        misaligned = |addr_q[ALIGN_BITS-1:0];
    end

    assign start_o      = start_req && !misaligned;
    assign chan_o       = mode_q[MODE_CHAN_BIT];
    assign inc_o        = mode_q[MODE_INC_BIT];
    assign xfer_addr_o  = addr_q;
    assign hold_o       = ~chrst_q;
    assign done_mask_o  = dmsk_q;
    assign fault_mask_o = fmsk_q;

    // Configuration registers: mode, buffer address, channel holds, masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            addr_q  <= '0;
            chrst_q <= 2'b11;
            dmsk_q  <= '1;
            fmsk_q  <= '1;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_MODE:      mode_q  <= reg_wdata[31:0];
                OFS_BUFADDR:   addr_q  <= reg_wdata[ADDR_W-1:0];
                OFS_CHRST:     chrst_q <= reg_wdata[CHRST_LO+1:CHRST_LO];
                OFS_DONE_MSK:  dmsk_q  <= reg_wdata[31:0];
                OFS_FAULT_MSK: fmsk_q  <= reg_wdata[31:0];
                default: ;
            endcase
        end
    end

    // Per-channel flags: set by events, cleared by writing 0 to their bit.
    for (genvar c = 0; c < 2; c++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_q[c]  <= 1'b0;
                fault_q[c] <= 1'b0;
            end else begin
                done_q[c] <= ((reg_we && reg_addr == OFS_DONE)
                                 ? done_q[c] & reg_wdata[FLAG_LO+c] : done_q[c])
                             | (done_i && (done_chan_i == c[0]));
                fault_q[c] <= ((reg_we && reg_addr == OFS_FAULT)
                                 ? fault_q[c] & reg_wdata[FLAG_LO+c] : fault_q[c])
                             | (start_req && misaligned && (mode_q[MODE_CHAN_BIT] == c[0]));
            end
        end
    end

    // Interrupt: any flag whose mask bit is open.
    assign irq_o = |(done_q & ~dmsk_q[FLAG_LO+1:FLAG_LO])
                 | |(fault_q & ~fmsk_q[FLAG_LO+1:FLAG_LO]);

    // Read-back multiplexer.
    always_comb begin
        chrst_view = '1;
        chrst_view[CHRST_LO+1:CHRST_LO] = chrst_q;
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE:      reg_rdata[31:0] = mode_q;
            OFS_CHRST:     reg_rdata[31:0] = chrst_view;
            OFS_DONE:      reg_rdata[FLAG_LO+1:FLAG_LO] = done_q;
            OFS_DONE_MSK:  reg_rdata[31:0] = dmsk_q;
            OFS_FAULT:     reg_rdata[FLAG_LO+1:FLAG_LO] = fault_q;
            OFS_FAULT_MSK: reg_rdata[31:0] = fmsk_q;
            OFS_BUFADDR:   reg_rdata[ADDR_W-1:0] = addr_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/sd_dma_mover.sv
// Beat mover of the SD DMA engine.
// Channel 0: memory read, then push to the card stream. Channel 1: pull from the
// card stream, then memory write. One word per beat; a held channel aborts.
// Assumes start_i only when idle, with an already aligned address.
module sd_dma_mover
    import sd_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEAT_W = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chan_i,
    input  logic              inc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BEAT_W-1:0] beats_i,
    input  logic [1:0]        hold_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              done_chan_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    mv_state_e         state_q;
    logic              chan_q;
    logic              inc_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] left_q;
    logic [DATA_W-1:0] word_q;
    logic              abort;
    logic              beat_fin;

    // Beat completion and abort detection.
    always_comb begin
        abort    = (state_q != MV_IDLE) && hold_i[chan_q];
        beat_fin = ((state_q == MV_MEM) && chan_q && mem_ack)
                || ((state_q == MV_CARD) && !chan_q && tx_ready);
    end

    // Transfer sequencing, address stepping and beat counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MV_IDLE;
            chan_q  <= 1'b0;
            inc_q   <= 1'b0;
            done_q  <= 1'b0;
            addr_q  <= '0;
            left_q  <= '0;
            word_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                state_q <= MV_IDLE;
            end else if (state_q == MV_IDLE) begin
                if (start_i) begin
                    chan_q <= chan_i;
                    inc_q  <= inc_i;
                    addr_q <= addr_i;
                    left_q <= beats_i;
                    if (beats_i == '0) done_q  <= 1'b1;
                    else               state_q <= chan_i ? MV_CARD : MV_MEM;
                end
            end else if (beat_fin) begin
                if (left_q == BEAT_W'(1)) begin
                    state_q <= MV_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    left_q  <= left_q - BEAT_W'(1);
                    addr_q  <= inc_q ? addr_q + STEP : addr_q;
                    state_q <= chan_q ? MV_CARD : MV_MEM;
                end
            end else if (state_q == MV_MEM && !chan_q && mem_ack) begin
                word_q  <= mem_rdata;
                state_q <= MV_CARD;
            end else if (state_q == MV_CARD && chan_q && rx_valid) begin
                word_q  <= rx_data;
                state_q <= MV_MEM;
            end
        end
    end

    assign busy_o      = (state_q != MV_IDLE);
    assign done_o      = done_q;
    assign done_chan_o = chan_q;
    assign mem_req     = (state_q == MV_MEM);
    assign mem_we      = chan_q;
    assign mem_addr    = addr_q;
    assign mem_wdata   = word_q;
    assign tx_valid    = (state_q == MV_CARD) && !chan_q;
    assign tx_data     = word_q;
    assign rx_ready    = (state_q == MV_CARD) && chan_q;
endmodule

// File: rtl/sd_dma_engine.sv
// Top of the SD host single-segment DMA engine.
// Ties the register file to the beat mover and derives the beat count from the
// block count and block size ports. Assumes blk_size is a multiple of the word size.
module sd_dma_engine
    import sd_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int BSZ_W      = 12,
    parameter int ALIGN_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic [CNT_W-1:0]  blk_cnt,
    input  logic [BSZ_W-1:0]  blk_size,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              irq
);
    localparam int WSH    = $clog2(DATA_W / 8);
    localparam int BYTE_W = CNT_W + BSZ_W;
    localparam int BEAT_W = BYTE_W - WSH;

    logic              mv_busy, mv_done, mv_done_chan;
    logic              mv_start, sel_chan, sel_inc;
    logic [ADDR_W-1:0] xfer_addr;
    logic [1:0]        chan_hold;
    logic [31:0]       done_mask, fault_mask;
    logic [BYTE_W-1:0] xfer_bytes;
    logic [BEAT_W-1:0] xfer_beats;
    logic              unused_lo;

    // Transfer length in bytes and in words.
    assign xfer_bytes = BYTE_W'(blk_cnt) * BYTE_W'(blk_size);
    assign xfer_beats = xfer_bytes[BYTE_W-1:WSH];
    assign unused_lo  = ^xfer_bytes[WSH-1:0];

    sd_dma_regs #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(mv_busy), .done_i(mv_done), .done_chan_i(mv_done_chan),
        .start_o(mv_start), .chan_o(sel_chan), .inc_o(sel_inc), .xfer_addr_o(xfer_addr),
        .hold_o(chan_hold), .done_mask_o(done_mask), .fault_mask_o(fault_mask), .irq_o(irq)
    );

    sd_dma_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_mover (
        .clk(clk), .rst_n(rst_n),
        .start_i(mv_start), .chan_i(sel_chan), .inc_i(sel_inc), .addr_i(xfer_addr),
        .beats_i(xfer_beats), .hold_i(chan_hold),
        .busy_o(mv_busy), .done_o(mv_done), .done_chan_o(mv_done_chan),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );
endmodule

// File: rtl/sd_dma_chk.sv
// Protocol and control checker for the SD DMA engine, bound to the top module.
// Assumes the default 32-bit address and data widths and 128-byte alignment.
module sd_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        mem_we,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [31:0] tx_data,
    input logic        rx_ready,
    input logic        irq,
    input logic [31:0] done_mask,
    input logic [31:0] fault_mask,
    input logic [1:0]  hold,
    input logic        start,
    input logic [31:0] xfer_addr
);
    // R3: an unaccepted memory request holds its address and direction.
    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && hold == 2'b00) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: an unaccepted outgoing word holds its data.
    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && hold == 2'b00) |=> (tx_valid && $stable(tx_data)));

    // R4: memory side and card side are never requested in the same cycle.
    p_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && (tx_valid || rx_ready)));

    // R7: the mover is only ever started on an aligned buffer.
    p_start_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (xfer_addr[6:0] == 7'd0));

    // R9: with both channels held, all bus activity stops.
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold == 2'b11) |=> (!mem_req && !tx_valid && !rx_ready));

    // R11: with every flag masked, the interrupt stays low.
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (&done_mask[17:16] && &fault_mask[17:16]) |-> !irq);
endmodule

bind sd_dma_engine sd_dma_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_we(mem_we),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_ready(rx_ready),
    .irq(irq), .done_mask(done_mask), .fault_mask(fault_mask), .hold(chan_hold),
    .start(mv_start), .xfer_addr(xfer_addr)
);

// File: tb/sd_dma_engine_tb.sv
module sd_dma_engine_tb;
    localparam logic [11:0] A_MODE = 12'h820, A_CTRL = 12'h828, A_RST = 12'h830,
                            A_DONE = 12'h840, A_DMSK = 12'h848, A_FLT = 12'h850,
                            A_FMSK = 12'h858, A_ADDR = 12'h880;

    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0;
    logic [11:0] reg_addr = 0;
    logic [63:0] reg_wdata = 0, reg_rdata;
    logic [31:0] blk_cnt = 0;
    logic [11:0] blk_size = 0;
    logic        mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic        tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;
    logic [31:0] tx_data, rx_data = 0;

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [31:0] model [256];
    logic [31:0] tx_log [64];
    logic [31:0] rd_log [64];
    logic [31:0] wr_alog [64];
    logic [31:0] wr_dlog [64];
    int tx_n = 0, rd_n = 0, wr_n = 0, rx_k = 0;
    logic [63:0] rv;

    always #10 clk = ~clk;   // 50 MHz

    sd_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_cnt(blk_cnt), .blk_size(blk_size),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .irq(irq)
    );

    function automatic logic [31:0] init_word(int i);
        return 32'hC0DE_0000 ^ (32'(i) * 32'h0001_0103);
    endfunction
    function automatic logic [31:0] rx_word(int k);
        return 32'h5A00_0000 + 32'(k) * 32'h0102_0305;
    endfunction
    function automatic int exp_beats(int cnt, int bsz);
        return cnt * bsz / 4;
    endfunction
    function automatic logic [31:0] exp_addr(logic [31:0] base, int i, bit inc);
        return inc ? base + 32'(4 * i) : base;
    endfunction

    // Random memory, card-out and card-in responders, driven away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 0; tx_ready = 0; rx_valid = 0;
        end else begin
            mem_ack = mem_req && (($urandom % 4) != 0);
            if (mem_ack) begin
                if (mem_we) begin
                    model[mem_addr[9:2]] = mem_wdata;
                    wr_alog[wr_n & 63] = mem_addr; wr_dlog[wr_n & 63] = mem_wdata; wr_n++;
                end else begin
                    mem_rdata = model[mem_addr[9:2]];
                    rd_log[rd_n & 63] = mem_addr; rd_n++;
                end
            end
            tx_ready = tx_valid && (($urandom % 3) != 0);
            if (tx_ready) begin tx_log[tx_n & 63] = tx_data; tx_n++; end
            rx_valid = rx_ready && (($urandom % 3) != 0);
            if (rx_valid) begin rx_data = rx_word(rx_k); rx_k++; end
        end
    end

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [11:0] a, logic [63:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic reg_read(logic [11:0] a, output logic [63:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_flag(int bitn);
        logic [63:0] d;
        for (int n = 0; n < 3000; n++) begin
            reg_read(A_DONE, d);
            if (d[bitn]) break;
        end
    endtask

    task automatic run_xfer(bit ch, bit inc, int cnt, int bsz, logic [31:0] base);
        blk_cnt = 32'(cnt); blk_size = 12'(bsz);
        reg_write(A_MODE, {32'd0, 15'd0, ch, 10'd0, 2'b11, 3'd0, inc});
        reg_write(A_ADDR, {32'd0, base});
        reg_write(A_CTRL, 64'd1);
        wait_flag(16 + ch);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        int t0, r0, w0, k0, beats, cnt, bsz;
        bit inc;
        logic [31:0] base;
        logic [31:0] snap [64];
        bit ok;
        process::self().srandom(32'h1234);
        for (int i = 0; i < 256; i++) model[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2: reset state
        reg_read(A_DMSK, rv); chk(rv == 64'hFFFF_FFFF, "R2 done mask", rv, 64'hFFFF_FFFF);
        reg_read(A_FMSK, rv); chk(rv == 64'hFFFF_FFFF, "R2 fault mask", rv, 64'hFFFF_FFFF);
        reg_read(A_DONE, rv); chk(rv == 0, "R2 done flags", rv, 0);
        reg_read(A_FLT, rv);  chk(rv == 0, "R2 fault flags", rv, 0);
        reg_read(A_RST, rv);  chk(rv == 64'hFFFF_FFFF, "R2 reset reg", rv, 64'hFFFF_FFFF);
        chk(irq == 0, "R2 irq", {63'd0, irq}, 0);

        // R1: readback, upper half zero
        reg_write(A_MODE, 64'hDEAD_BEEF_0001_0031);
        reg_read(A_MODE, rv); chk(rv == 64'h0001_0031, "R1 mode readback", rv, 64'h0001_0031);
        reg_write(A_ADDR, 64'hFFFF_0000_0000_0180);
        reg_read(A_ADDR, rv); chk(rv == 64'h180, "R1 addr readback", rv, 64'h180);

        // R12: control write with bit 0 clear starts nothing
        reg_write(A_MODE, 64'h30); reg_write(A_ADDR, 0); blk_cnt = 1; blk_size = 16;
        r0 = rd_n;
        reg_write(A_CTRL, 64'h2);
        repeat (20) @(negedge clk);
        reg_read(A_DONE, rv);
        chk(rd_n == r0 && rv == 0, "R12 start bit clear", 64'(rd_n - r0), 0);

        // R3 R5 R6: random channel 0 transfers
        for (int it = 0; it < 6; it++) begin
            cnt = 1 + int'($urandom % 3); bsz = 4 << ($urandom % 4);
            inc = (it < 2) ? bit'(it) : bit'($urandom % 2);
            base = 32'(($urandom % 4) * 128);
            beats = exp_beats(cnt, bsz);
            t0 = tx_n; r0 = rd_n; w0 = wr_n;
            run_xfer(0, inc, cnt, bsz, base);
            repeat (3) @(negedge clk);
            chk(tx_n - t0 == beats, "R6 ch0 word count", 64'(tx_n - t0), 64'(beats));
            ok = 1;
            for (int i = 0; i < beats; i++) begin
                if (tx_log[(t0 + i) & 63] != model[exp_addr(base, i, inc) >> 2 & 255]) ok = 0;
                if (rd_log[(r0 + i) & 63] != exp_addr(base, i, inc)) ok = 0;
            end
            chk(ok, inc ? "R5 R3 ch0 data/incrementing addr" : "R5 R3 ch0 data/fixed addr",
                64'(tx_log[t0 & 63]), 64'(model[base[9:2]]));
            chk(wr_n == w0, "R3 ch0 no memory writes", 64'(wr_n - w0), 0);
            reg_read(A_DONE, rv); chk(rv == 64'h1_0000, "R6 ch0 done flag", rv, 64'h1_0000);
            reg_write(A_DONE, 0);
        end

        // R4 R5 R6: random channel 1 transfers
        for (int it = 0; it < 6; it++) begin
            cnt = 1 + int'($urandom % 3); bsz = 4 << ($urandom % 4);
            inc = (it < 2) ? bit'(it) : bit'($urandom % 2);
            base = 32'(($urandom % 4) * 128);
            beats = exp_beats(cnt, bsz);
            w0 = wr_n; k0 = rx_k;
            run_xfer(1, inc, cnt, bsz, base);
            repeat (3) @(negedge clk);
            chk(wr_n - w0 == beats, "R6 ch1 word count", 64'(wr_n - w0), 64'(beats));
            ok = 1;
            for (int i = 0; i < beats; i++) begin
                if (wr_dlog[(w0 + i) & 63] != rx_word(k0 + i)) ok = 0;
                if (wr_alog[(w0 + i) & 63] != exp_addr(base, i, inc)) ok = 0;
            end
            chk(ok, "R4 R5 ch1 write data/addr", 64'(wr_dlog[w0 & 63]), 64'(rx_word(k0)));
            reg_read(A_DONE, rv); chk(rv == 64'h2_0000, "R6 ch1 done flag", rv, 64'h2_0000);
            reg_write(A_DONE, 0);
        end

        // R6: zero length completes with no activity
        r0 = rd_n;
        run_xfer(0, 1, 0, 16, 0);
        reg_read(A_DONE, rv);
        chk(rv == 64'h1_0000 && rd_n == r0, "R6 zero length", rv, 64'h1_0000);
        reg_write(A_DONE, 0);

        // R7: misaligned start
        w0 = wr_n; k0 = rx_k;
        blk_cnt = 1; blk_size = 16;
        reg_write(A_MODE, 64'h1_0031); reg_write(A_ADDR, 64'h104); reg_write(A_CTRL, 1);
        repeat (20) @(negedge clk);
        reg_read(A_FLT, rv); chk(rv == 64'h2_0000, "R7 fault flag ch1", rv, 64'h2_0000);
        chk(wr_n == w0 && rx_k == k0, "R7 no activity", 64'(wr_n - w0), 0);
        reg_read(A_DONE, rv); chk(rv == 0, "R7 no done", rv, 0);

        // R11: irq follows mask
        chk(irq == 0, "R11 irq masked", {63'd0, irq}, 0);
        reg_write(A_FMSK, 64'hFFFD_FFFF);
        @(negedge clk); chk(irq == 1, "R11 irq unmasked", {63'd0, irq}, 1);
        reg_write(A_FLT, 0);
        @(negedge clk); chk(irq == 0, "R11 irq after clear", {63'd0, irq}, 0);
        reg_write(A_FMSK, 64'hFFFF_FFFF);

        // R8: start while busy is ignored
        for (int i = 0; i < 64; i++) snap[i] = model[i + 32];
        t0 = tx_n; r0 = rd_n;
        blk_cnt = 2; blk_size = 32;
        reg_write(A_MODE, 64'h31); reg_write(A_ADDR, 64'h80); reg_write(A_CTRL, 1);
        reg_write(A_ADDR, 64'h200); reg_write(A_CTRL, 1);
        wait_flag(16); repeat (3) @(negedge clk);
        ok = (tx_n - t0 == 16);
        for (int i = 0; i < 16; i++)
            if (rd_log[(r0 + i) & 63] != 32'h80 + 32'(4 * i) || tx_log[(t0 + i) & 63] != snap[i]) ok = 0;
        chk(ok, "R8 restart ignored", 64'(tx_n - t0), 16);
        reg_write(A_DONE, 0);

        // R9: abort channel 1 mid-transfer
        w0 = wr_n;
        blk_cnt = 2; blk_size = 32;
        reg_write(A_MODE, 64'h1_0031); reg_write(A_ADDR, 64'h100); reg_write(A_CTRL, 1);
        for (int n = 0; n < 2000 && wr_n - w0 < 2; n++) @(negedge clk);
        reg_write(A_RST, 64'hFFFF_FDFF);
        repeat (10) @(negedge clk);
        r0 = wr_n;
        repeat (40) @(negedge clk);
        chk(wr_n == r0 && wr_n - w0 < 16, "R9 abort stops writes", 64'(wr_n - w0), 64'(r0 - w0));
        reg_read(A_DONE, rv); chk(rv == 0, "R9 no done after abort", rv, 0);
        reg_read(A_RST, rv); chk(rv == 64'hFFFF_FDFF, "R9 reset reg readback", rv, 64'hFFFF_FDFF);
        k0 = rx_k;
        reg_write(A_CTRL, 1);
        repeat (30) @(negedge clk);
        reg_read(A_DONE, rv);
        chk(rx_k == k0 && wr_n == r0 && rv == 0, "R9 held start ignored", 64'(rx_k - k0), 0);
        reg_write(A_RST, 64'hFFFF_FFFF);

        // R10: selective flag clearing
        run_xfer(0, 1, 0, 4, 0);
        run_xfer(1, 1, 0, 4, 0);
        reg_read(A_DONE, rv); chk(rv == 64'h3_0000, "R10 both flags", rv, 64'h3_0000);
        reg_write(A_DONE, 64'h2_0000);
        reg_read(A_DONE, rv); chk(rv == 64'h2_0000, "R10 keep ch1 flag", rv, 64'h2_0000);
        reg_write(A_DMSK, 64'hFFFD_FFFF);
        @(negedge clk); chk(irq == 1, "R11 done irq", {63'd0, irq}, 1);
        reg_write(A_DONE, 0);
        reg_read(A_DONE, rv); chk(rv == 0, "R10 write zero clears", rv, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule